// File: doc/BRIEF.md
# ECC Memory Diagnostic Register Port

This block gives software a raw path into an error-corrected memory for self-test and fault injection. Software loads a target byte address into an address register. It then reads or writes one of two window registers. The check-bit window reaches the check bits of the 64-bit word that holds that address. The data window reaches the 32-bit data word at that address. Every window access becomes one access on a raw memory port that goes around the encoder and decoder. The register bus is held in wait states until the memory acknowledges, and this applies to writes as well as reads.

A completed data-window read also loads a status register. The status register reports whether the memory saw a correctable or an uncorrectable error, and it holds a mask with one bit per byte lane that marks where the correctable errors were found. The status register keeps its value until the next data-window read completes.

Register select codes on `reg_sel`: 0 is the address register, 1 is the check-bit window, 2 is the data window and 3 is the status register. The status layout is: bit 0 is the correctable flag, bit 1 is the uncorrectable flag, bits 8 to 15 are the lane mask, and all other bits read zero.

Top module: `ecc_diag_port`

## Requirements
- R1: After reset, `reg_ready` and `mem_req` are low, and both the address register and the status register read as zero.
- R2: An address-register or status-register access raises `reg_ready` for exactly one cycle, one cycle after the request is taken. A write to select 0 is read back unchanged.
- R3: A check-bit window access (select 1) drives `mem_chk`=1 and drives `mem_addr` as the address register with bits 2:0 cleared.
- R4: A data window access (select 2) drives `mem_chk`=0 and drives `mem_addr` as the address register with bits 1:0 cleared.
- R5: A window access keeps `reg_ready` low while `mem_req` is high, for both reads and writes. `reg_ready` rises one cycle after the cycle in which `mem_ack` is sampled, so an access with an acknowledge latency of L cycles completes in L+1 cycles.
- R6: A window read returns `mem_rdata` as captured at acknowledge. A check-bit read keeps only the low 16 bits and zeroes the rest.
- R7: `mem_we` and `mem_wdata` are held stable while `mem_req` waits for acknowledge. A check-bit write sends only the low 16 bits of the register write data, and the upper bits are zero.
- R8: A completed data-window read loads the status register: bit 0 is set when any `mem_cerr` lane is set and `mem_uerr` is low, bit 1 copies `mem_uerr`, and bits 15:8 copy `mem_cerr`.
- R9: When `mem_uerr` is high at the acknowledge of a data read, the status lane mask and the correctable flag read as zero.
- R10: Check-bit reads, window writes and address-register accesses leave the status register unchanged, whatever error inputs are present.
- R11: A write to the status register (select 3) has no effect on its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request, held until `reg_ready` |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_sel | input | 2 | Register select (0 address, 1 check bits, 2 data, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while `reg_ready` is high |
| reg_ready | output | 1 | One-cycle access completion |
| mem_req | output | 1 | Raw memory request, held until `mem_ack` |
| mem_we | output | 1 | Raw memory write |
| mem_chk | output | 1 | 1 selects the check bits, 0 selects the data |
| mem_addr | output | 32 | Aligned byte address |
| mem_wdata | output | 32 | Raw write data |
| mem_rdata | input | 32 | Raw read data |
| mem_ack | input | 1 | Memory completion strobe |
| mem_cerr | input | 8 | Per-lane correctable-error flags at acknowledge |
| mem_uerr | input | 1 | Uncorrectable-error flag at acknowledge |

## Verification
At the acknowledge of a data read, two things happen on the same clock edge: the block returns the read data to the bus and it updates the status register. The bench provokes this with a data read whose acknowledge carries error flags. It then judges both results: the value returned to the bus, and the status read back in the very next access.

The bench also presents error flags at the acknowledge of check-bit reads and of writes. These accesses must not load the status register, and the next status read shows whether any of them did.

// File: rtl/ediag_pkg.sv
package ediag_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CHK  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM,
        ST_DONE
    } fsm_e;

    typedef struct packed {
        logic we;
        logic chk;
    } mem_op_t;

    localparam int STAT_MASK_LSB = 8;

endpackage

// File: rtl/ediag_align.sv
module ediag_align #(
    parameter int ADDR_W     = 32,
    parameter int CHK_SHIFT  = 3,
    parameter int DATA_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              chk,
    output logic [ADDR_W-1:0] aligned
);
    localparam int MAX_SHIFT = (CHK_SHIFT > DATA_SHIFT) ? CHK_SHIFT : DATA_SHIFT;

    always_comb begin
        aligned = addr;
        for (int i = 0; i < MAX_SHIFT; i++) begin
            if (chk ? (i < CHK_SHIFT) : (i < DATA_SHIFT)) aligned[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ediag_status.sv
module ediag_status
    import ediag_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [LANES-1:0]  lanes,
    input  logic              uerr,
    output logic [DATA_W-1:0] word
);
    logic             corr_q;
    logic             unc_q;
    logic [LANES-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            corr_q <= 1'b0;
            unc_q  <= 1'b0;
            mask_q <= '0;
        end else if (upd) begin
            unc_q  <= uerr;
            corr_q <= (|lanes) & ~uerr;
            mask_q <= uerr ? '0 : lanes;
        end
    end

    always_comb begin
        word = '0;
        word[0] = corr_q;
        word[1] = unc_q;
        word[STAT_MASK_LSB +: LANES] = mask_q;
    end

    // R10: status holds unless a data read completes
    a_r10_status_hold: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(word));
endmodule

// File: rtl/ediag_ctrl.sv
module ediag_ctrl
    import ediag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CB_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    input  logic [DATA_W-1:0] stat_word,
    output logic              stat_upd,
    output logic [ADDR_W-1:0] addr_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_chk,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam logic [DATA_W-1:0] CB_MASK = {{(DATA_W-CB_W){1'b0}}, {CB_W{1'b1}}};

    fsm_e     state;
    mem_op_t  op;
    reg_sel_e sel_e;

    assign sel_e    = reg_sel_e'(sel);
    assign ready    = (state == ST_DONE);
    assign mem_we   = op.we;
    assign mem_chk  = op.chk;
    assign stat_upd = (state == ST_MEM) && mem_ack && !op.we && !op.chk;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op        <= '0;
            addr_q    <= '0;
            rdata     <= '0;
            mem_req   <= 1'b0;
            mem_wdata <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req) begin
                    case (sel_e)
                        SEL_ADDR: begin
                            if (we) addr_q <= wdata[ADDR_W-1:0];
                            rdata <= we ? '0 : DATA_W'(addr_q);
                            state <= ST_DONE;
                        end
                        SEL_STAT: begin
                            rdata <= we ? '0 : stat_word;
                            state <= ST_DONE;
                        end
                        default: begin
                            op.we     <= we;
                            op.chk    <= (sel_e == SEL_CHK);
                            mem_wdata <= (sel_e == SEL_CHK) ? (wdata & CB_MASK) : wdata;
                            mem_req   <= 1'b1;
                            state     <= ST_MEM;
                        end
                    endcase
                end
                ST_MEM: if (mem_ack) begin
                    mem_req <= 1'b0;
                    rdata   <= op.we ? '0 : (op.chk ? (mem_rdata & CB_MASK) : mem_rdata);
                    state   <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: bus stays stalled while the memory access is outstanding
    a_r5_stall_while_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !ready);
    // R2: completion is a single-cycle pulse
    a_r2_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);
    // R7: request and write data held until acknowledge
    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_wdata) && $stable(mem_we)));
endmodule

// File: rtl/ecc_diag_port.sv
module ecc_diag_port
    import ediag_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CB_W        = 16,
    parameter int LANES       = 8,
    parameter int WORD_BYTES  = 8,
    parameter int DWORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_chk,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic [LANES-1:0]  mem_cerr,
    input  logic              mem_uerr
);
    localparam int CHK_SHIFT  = $clog2(WORD_BYTES);
    localparam int DATA_SHIFT = $clog2(DWORD_BYTES);
    localparam logic [ADDR_W-1:0] CHK_LOW  = ADDR_W'((1 << CHK_SHIFT) - 1);
    localparam logic [ADDR_W-1:0] DATA_LOW = ADDR_W'((1 << DATA_SHIFT) - 1);

    logic [DATA_W-1:0] stat_word;
    logic              stat_upd;
    logic [ADDR_W-1:0] addr_q;

    ediag_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CB_W(CB_W)) u_ctrl (
        .clk(clk), .rst(rst), .req(reg_req), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .ready(reg_ready),
        .stat_word(stat_word), .stat_upd(stat_upd), .addr_q(addr_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_chk(mem_chk),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    ediag_align #(.ADDR_W(ADDR_W), .CHK_SHIFT(CHK_SHIFT), .DATA_SHIFT(DATA_SHIFT)) u_align (
        .addr(addr_q), .chk(mem_chk), .aligned(mem_addr)
    );

    ediag_status #(.LANES(LANES), .DATA_W(DATA_W)) u_status (
        .clk(clk), .rst(rst), .upd(stat_upd), .lanes(mem_cerr),
        .uerr(mem_uerr), .word(stat_word)
    );

    // R3: check-bit accesses land on a 64-bit boundary
    a_r3_chk_aligned: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_chk) |-> ((mem_addr & CHK_LOW) == '0));
    // R4: data accesses land on a 32-bit boundary
    a_r4_data_aligned: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_chk) |-> ((mem_addr & DATA_LOW) == '0));
endmodule

// File: tb/sim_ecc_diag_port.sv
module sim_ecc_diag_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ready;
    logic        mem_req, mem_we, mem_chk;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_cerr = '0;
    logic        mem_uerr = 1'b0;

    int checks = 0, errors = 0;
    bit done = 0;

    ecc_diag_port u0 (
        .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_chk(mem_chk), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_cerr(mem_cerr), .mem_uerr(mem_uerr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural memory responder and acknowledge log
    int          lat = 1, wait_cnt = 0;
    logic [31:0] rsp_data = '0;
    logic [7:0]  rsp_cerr = '0;
    logic        rsp_uerr = 1'b0;
    logic [31:0] log_addr, log_wdata;
    logic        log_chk, log_we;

    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            wait_cnt++;
            if (wait_cnt >= lat) begin
                mem_ack = 1'b1; mem_rdata = rsp_data;
                mem_cerr = rsp_cerr; mem_uerr = rsp_uerr;
                log_addr = mem_addr; log_wdata = mem_wdata;
                log_chk = mem_chk; log_we = mem_we;
                wait_cnt = 0;
            end
        end else begin
            mem_ack = 1'b0; mem_cerr = '0; mem_uerr = 1'b0; mem_rdata = '0;
        end
    end

    // per-clock model of the stall and hold rules
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = '0, prev_wd = '0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (mem_req) begin
                checks++;
                if (reg_ready) begin
                    errors++; $display("FAIL R5 ready=%0b expected 0 while mem_req high", reg_ready);
                end
            end
            if (prev_wait) begin
                checks++;
                if (!mem_req || mem_addr != prev_addr || mem_wdata != prev_wd) begin
                    errors++;
                    $display("FAIL R7 req=%0b addr=%h wdata=%h expected 1 %h %h",
                             mem_req, mem_addr, mem_wdata, prev_addr, prev_wd);
                end
            end
            prev_wait = mem_req && !mem_ack;
            prev_addr = mem_addr; prev_wd = mem_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic xfer(input logic [1:0] s, input logic w, input logic [31:0] d,
                        output logic [31:0] r, output int cyc);
        @(negedge clk);
        reg_sel = s; reg_we = w; reg_wdata = d; reg_req = 1'b1; cyc = 0;
        do begin @(negedge clk); cyc++; end while (!reg_ready && cyc < 1000);
        r = reg_rdata; reg_req = 1'b0;
    endtask

    function automatic logic [31:0] stat(input logic c, input logic u, input logic [7:0] m);
        return {16'h0, m, 6'h0, u, c};
    endfunction

    initial begin
        logic [31:0] r;
        int cyc;
        repeat (3) @(negedge clk);
        chk("R1 ready at reset", {31'h0, reg_ready}, 32'h0);
        chk("R1 mem_req at reset", {31'h0, mem_req}, 32'h0);
        rst = 1'b0;
        xfer(2'd0, 1'b0, 32'h0, r, cyc); chk("R1 address reg", r, 32'h0);
        xfer(2'd3, 1'b0, 32'h0, r, cyc); chk("R1 status reg", r, 32'h0);

        xfer(2'd0, 1'b1, 32'h1234_5677, r, cyc); chk("R2 write cycles", cyc, 1);
        xfer(2'd0, 1'b0, 32'h0, r, cyc); chk("R2 readback", r, 32'h1234_5677);

        lat = 3; rsp_cerr = 8'hFF; rsp_uerr = 1'b1;
        xfer(2'd1, 1'b1, 32'hABCD_5A5A, r, cyc);
        chk("R5 chk write cycles", cyc, 4);
        chk("R3 chk addr", log_addr, 32'h1234_5670);
        chk("R3 chk flag", {31'h0, log_chk}, 32'h1);
        chk("R7 chk wdata", log_wdata, 32'h0000_5A5A);
        xfer(2'd3, 1'b0, 32'h0, r, cyc); chk("R10 after chk write", r, 32'h0);

        lat = 1; rsp_data = 32'hFFFF_1234; rsp_cerr = 8'h81; rsp_uerr = 1'b0;
        xfer(2'd1, 1'b0, 32'h0, r, cyc);
        chk("R6 chk read", r, 32'h0000_1234);
        chk("R5 chk read cycles", cyc, 2);
        xfer(2'd3, 1'b0, 32'h0, r, cyc); chk("R10 after chk read", r, 32'h0);

        // data read: return value and status load on the same edge
        lat = 2; rsp_data = 32'hDEAD_BEEF; rsp_cerr = 8'h05;
        xfer(2'd2, 1'b0, 32'h0, r, cyc);
        chk("R6 data read", r, 32'hDEAD_BEEF);
        chk("R4 data addr", log_addr, 32'h1234_5674);
        chk("R4 data flag", {31'h0, log_chk}, 32'h0);
        xfer(2'd3, 1'b0, 32'h0, r, cyc); chk("R8 status", r, stat(1'b1, 1'b0, 8'h05));

        lat = 4; rsp_cerr = 8'h40; rsp_uerr = 1'b1;
        xfer(2'd2, 1'b1, 32'h0BAD_F00D, r, cyc);
        chk("R5 data write cycles", cyc, 5);
        chk("R7 data wdata", log_wdata, 32'h0BAD_F00D);
        chk("R7 write flag", {31'h0, log_we}, 32'h1);
        xfer(2'd3, 1'b0, 32'h0, r, cyc); chk("R10 after data write", r, stat(1'b1, 1'b0, 8'h05));

        xfer(2'd0, 1'b1, 32'h0000_0103, r, cyc);
        xfer(2'd3, 1'b0, 32'h0, r, cyc); chk("R10 after addr write", r, stat(1'b1, 1'b0, 8'h05));

        lat = 1; rsp_data = 32'h1111_2222; rsp_cerr = 8'h30; rsp_uerr = 1'b1;
        xfer(2'd2, 1'b0, 32'h0, r, cyc);
        chk("R4 data addr low bits", log_addr, 32'h0000_0100);
        xfer(2'd3, 1'b0, 32'h0, r, cyc); chk("R9 uncorrectable", r, stat(1'b0, 1'b1, 8'h00));

        xfer(2'd3, 1'b1, 32'hFFFF_FFFF, r, cyc);
        xfer(2'd3, 1'b0, 32'h0, r, cyc); chk("R11 status write ignored", r, stat(1'b0, 1'b1, 8'h00));

        rsp_cerr = 8'h00; rsp_uerr = 1'b0;
        xfer(2'd1, 1'b0, 32'h0, r, cyc);
        chk("R3 chk addr low bits", log_addr, 32'h0000_0100);
        xfer(2'd2, 1'b0, 32'h0, r, cyc);
        xfer(2'd3, 1'b0, 32'h0, r, cyc); chk("R8 clean overwrite", r, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1; checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule